// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register side of a simple serial port. Software reaches it over a word-addressed read/write bus. It keeps the control words, two status words and a test word. It passes each transmitted byte to a byte-stream output and holds one received character for software. Serial bit timing is handled elsewhere. The block's job is bookkeeping: it stores control words, raises and lowers the ready flags, performs the soft reset, and combines the ready flags into one level interrupt.

A received character sits in a single-entry holding buffer until software reads the data word. While the buffer is occupied, the input side is told to hold off. Reading the data word while it is occupied returns the character with a valid marker and frees the buffer. The baud-rate words are only stored and read back.

Top module: `sercom_regfile`

## Requirements
- R1: After reset the words read as follows: control-1 (0x20) 0x0000, control-2 (0x21) 0x0001, control-3 (0x22) 0x0700, modulator (0x2A) 0x0000, baud count (0x2B) 0x0004, status-1 (0x25) 0x6040, status-2 (0x26) 0x4028, test (0x2D) 0x0060, and the data word (0x00) 0x4000 (error flag, bit 14).
- R2: An offset with no register reads zero, and a write to it changes nothing. Control-4 (0x23) and the baud increment offset (0x29) also read zero.
- R3: Writes to control-1, control-3, FIFO control (0x24), modulator and the millisecond word (0x2C) keep bits 15:0 only. A write to 0x29 is stored in the baud count and read back at 0x2B.
- R4: A control-2 write with bit 0 clear does a full soft reset, restoring the R1 values and emptying the buffer. Control-2 then holds the written bits 15:0 with bit 0 forced to 1. FIFO control and the millisecond word keep their values.
- R5: A character on the receive input is taken only while `rx_ready` is high, which means the buffer is empty. Taking it stores the byte, sets status-1 bit 9 and status-2 bit 0, clears test bit 5 and lowers `rx_ready`. A character offered while the buffer is full is dropped.
- R6: A received break loads the value 0x0800 (bit 11) into the buffer and sets the same flags as a character.
- R7: Reading the data word with the buffer full returns the stored value with bit 15 set, and frees the buffer (undoing the R5 flags). A read with the buffer empty returns the stored value without bit 15 and has no side effect.
- R8: A write to 0x10 while control-2 bit 2 is set gives a one-cycle `tx_valid` pulse on the next cycle, carrying bits 7:0 of the write. With bit 2 clear the write is dropped.
- R9: A write to status-1 clears only bits in mask 0x9DB0 where the written value is 1. A write to status-2 does the same with mask 0x9FD6. The ready bits (status-1 bits 13, 9, 14, 6; status-2 bits 0, 3, 5, 14) are untouched.
- R10: `irq` is high when status-1 bit 9 and control-1 bit 9 are both set. It is also high when status-1 bit 13, control-1 bit 13 and control-1 bit 6 are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the current offset (combinational) |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive event offered |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Event is a break, not a character |
| rx_ready | output | 1 | Buffer empty, input may be taken |
| irq | output | 1 | Level interrupt |

## Verification
Software may read the data word in the same cycle that the receive side offers a new character. The bench fills the buffer, then issues a data read while it holds `rx_valid` with a second byte. The read must return the first byte with its valid marker. `rx_ready` must stay low during that cycle, so the second byte is not taken then. It must be taken one cycle later, and the next read must return it.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int REG_W = 16;

    // word offsets
    localparam int OFS_RXD  = 'h00;
    localparam int OFS_TXD  = 'h10;
    localparam int OFS_CTL1 = 'h20;
    localparam int OFS_CTL2 = 'h21;
    localparam int OFS_CTL3 = 'h22;
    localparam int OFS_CTL4 = 'h23;
    localparam int OFS_FIFO = 'h24;
    localparam int OFS_STS1 = 'h25;
    localparam int OFS_STS2 = 'h26;
    localparam int OFS_BINC = 'h29;
    localparam int OFS_BMOD = 'h2A;
    localparam int OFS_BCNT = 'h2B;
    localparam int OFS_MSEC = 'h2C;
    localparam int OFS_TST  = 'h2D;

    // bit positions
    localparam int S1_TRDY   = 13;
    localparam int S1_RRDY   = 9;
    localparam int S2_RDR    = 0;
    localparam int C1_TXEIE  = 6;
    localparam int C2_SRST   = 0;
    localparam int C2_TXEN   = 2;
    localparam int TST_RXEMP = 5;
    localparam int TST_TXEMP = 6;
    localparam int RXD_CHRDY = 15;

    localparam logic [REG_W-1:0] S1_INIT  = 16'h6040;
    localparam logic [REG_W-1:0] S2_INIT  = 16'h4028;
    localparam logic [REG_W-1:0] S1_W1C   = 16'h9DB0;
    localparam logic [REG_W-1:0] S2_W1C   = 16'h9FD6;
    localparam logic [REG_W-1:0] RXD_ERR  = 16'h4000;
    localparam logic [REG_W-1:0] RXD_BRK  = 16'h0800;
    localparam logic [REG_W-1:0] CTL3_INIT = 16'h0700;
    localparam logic [REG_W-1:0] BCNT_INIT = 16'h0004;

    typedef struct packed {
        logic [REG_W-1:0] ctl1;
        logic [REG_W-1:0] ctl2;
        logic [REG_W-1:0] ctl3;
        logic [REG_W-1:0] fifo;
        logic [REG_W-1:0] sts1;
        logic [REG_W-1:0] sts2;
        logic [REG_W-1:0] bmod;
        logic [REG_W-1:0] bcnt;
        logic [REG_W-1:0] msec;
    } regs_t;

    function automatic regs_t regs_init(input logic [REG_W-1:0] fifo_keep,
                                        input logic [REG_W-1:0] msec_keep);
        regs_t r;
        r.ctl1 = '0;
        r.ctl2 = REG_W'(1) << C2_SRST;
        r.ctl3 = CTL3_INIT;
        r.fifo = fifo_keep;
        r.sts1 = S1_INIT;
        r.sts2 = S2_INIT;
        r.bmod = '0;
        r.bcnt = BCNT_INIT;
        r.msec = msec_keep;
        return r;
    endfunction

endpackage

// File: rtl/sercom_rx_hold.sv
module sercom_rx_hold
    import sercom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             take,
    input  logic [REG_W-1:0] din,
    input  logic             drain,
    output logic             full,
    output logic [REG_W-1:0] hold
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
            hold <= RXD_ERR;
        end else if (take) begin
            full <= 1'b1;
            hold <= din;
        end else if (drain) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/sercom_tx_port.sv
module sercom_tx_port (
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [7:0] din,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= fire;
            if (fire) tx_byte <= din;
        end
    end
endmodule

// File: rtl/sercom_irq.sv
module sercom_irq
    import sercom_pkg::*;
(
    input  logic [REG_W-1:0] sts1,
    input  logic [REG_W-1:0] ctl1,
    output logic             irq
);
    logic [REG_W-1:0] pend;
    always_comb begin
        pend = sts1 & ctl1;
        if (!ctl1[C1_TXEIE]) pend[S1_TRDY] = 1'b0;
        irq = pend[S1_TRDY] | pend[S1_RRDY];
    end
endmodule

// File: rtl/sercom_regfile.sv
module sercom_regfile
    import sercom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_break,
    output logic              rx_ready,
    output logic              irq
);
    regs_t regs_q, regs_d;
    logic  wr_en, rd_en, soft_rst, rd_clr, rx_take, tx_fire;
    logic  rx_full;
    logic [REG_W-1:0] rx_hold, wlo, sts1_v, sts2_v, tst_v, rdv, rx_din;

    assign wr_en    = req_valid &  req_write;
    assign rd_en    = req_valid & ~req_write;
    assign wlo      = req_wdata[REG_W-1:0];
    assign soft_rst = wr_en && (req_addr == ADDR_W'(OFS_CTL2)) && !wlo[C2_SRST];
    assign rd_clr   = rd_en && (req_addr == ADDR_W'(OFS_RXD)) && rx_full;
    assign rx_ready = ~rx_full;
    assign rx_take  = rx_valid && rx_ready;
    assign rx_din   = rx_break ? RXD_BRK : {{(REG_W-8){1'b0}}, rx_byte};
    assign tx_fire  = wr_en && (req_addr == ADDR_W'(OFS_TXD)) && regs_q.ctl2[C2_TXEN];

    // status views: receive flags follow the holding buffer
    always_comb begin
        sts1_v = regs_q.sts1;
        sts1_v[S1_RRDY] = rx_full;
        sts2_v = regs_q.sts2;
        sts2_v[S2_RDR] = rx_full;
        tst_v = '0;
        tst_v[TST_TXEMP] = 1'b1;
        tst_v[TST_RXEMP] = ~rx_full;
    end

    always_comb begin
        regs_d = regs_q;
        if (soft_rst) begin
            regs_d = regs_init(regs_q.fifo, regs_q.msec);
            regs_d.ctl2 = wlo | (REG_W'(1) << C2_SRST);
        end else if (wr_en) begin
            case (int'(req_addr))
                OFS_CTL1: regs_d.ctl1 = wlo;
                OFS_CTL2: regs_d.ctl2 = wlo;
                OFS_CTL3: regs_d.ctl3 = wlo;
                OFS_FIFO: regs_d.fifo = wlo;
                OFS_STS1: regs_d.sts1 = regs_q.sts1 & ~(wlo & S1_W1C);
                OFS_STS2: regs_d.sts2 = regs_q.sts2 & ~(wlo & S2_W1C);
                OFS_BINC: regs_d.bcnt = wlo;
                OFS_BMOD: regs_d.bmod = wlo;
                OFS_MSEC: regs_d.msec = wlo;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= regs_init('0, '0);
        else     regs_q <= regs_d;
    end

    always_comb begin
        case (int'(req_addr))
            OFS_RXD:  rdv = rx_hold | (REG_W'(rx_full) << RXD_CHRDY);
            OFS_CTL1: rdv = regs_q.ctl1;
            OFS_CTL2: rdv = regs_q.ctl2;
            OFS_CTL3: rdv = regs_q.ctl3;
            OFS_FIFO: rdv = regs_q.fifo;
            OFS_STS1: rdv = sts1_v;
            OFS_STS2: rdv = sts2_v;
            OFS_BMOD: rdv = regs_q.bmod;
            OFS_BCNT: rdv = regs_q.bcnt;
            OFS_MSEC: rdv = regs_q.msec;
            OFS_TST:  rdv = tst_v;
            default:  rdv = '0;
        endcase
        rd_data = DATA_W'(rdv);
    end

    sercom_rx_hold u_rx (
        .clk(clk), .rst(rst), .flush(soft_rst), .take(rx_take),
        .din(rx_din), .drain(rd_clr), .full(rx_full), .hold(rx_hold)
    );

    sercom_tx_port u_tx (
        .clk(clk), .rst(rst), .fire(tx_fire), .din(req_wdata[7:0]),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    sercom_irq u_irq (
        .sts1(sts1_v), .ctl1(regs_q.ctl1), .irq(irq)
    );
endmodule

// File: rtl/sercom_regfile_chk.sv
module sercom_regfile_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [15:0]       ctl1_q,
    input logic [15:0]       ctl2_q,
    input logic              soft_rst,
    input logic              rd_clr,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              rx_full,
    input logic [15:0]       rx_hold,
    input logic              tx_valid,
    input logic              irq
);
    assert_srst_reads_one_R4: assert property (@(posedge clk) disable iff (rst)
        ctl2_q[0]);

    assert_rx_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && !soft_rst) |=> rx_full);

    assert_rx_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_clr && !soft_rst) |=> (rx_full && $stable(rx_hold)));

    assert_read_frees_R7: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> !rx_full);

    assert_tx_gated_R8: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(req_valid && req_write &&
                           req_addr == ADDR_W'('h10) && ctl2_q[2]));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctl1_q[9] && !(ctl1_q[6] && ctl1_q[13])) |-> !irq);
endmodule

bind sercom_regfile sercom_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .ctl1_q(regs_q.ctl1), .ctl2_q(regs_q.ctl2),
    .soft_rst(soft_rst), .rd_clr(rd_clr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_full(rx_full), .rx_hold(rx_hold),
    .tx_valid(tx_valid), .irq(irq)
);

// File: tb/sercom_regfile_tb.sv
module sercom_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sercom_regfile u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_break(rx_break), .rx_ready(rx_ready), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        req_valid = 1'b0; req_addr = '0;
        #1;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic rx_send(input logic [7:0] b, input logic brk);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b; rx_break = brk;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctl1", 6'h20, 32'h0000);
        rd_chk("R1 ctl2", 6'h21, 32'h0001);
        rd_chk("R1 ctl3", 6'h22, 32'h0700);
        rd_chk("R1 bmod", 6'h2A, 32'h0000);
        rd_chk("R1 bcnt", 6'h2B, 32'h0004);
        rd_chk("R1 sts1", 6'h25, 32'h6040);
        rd_chk("R1 sts2", 6'h26, 32'h4028);
        rd_chk("R1 tst",  6'h2D, 32'h0060);
        rd_chk("R1 rxd",  6'h00, 32'h4000);
        chk("R1 rx_ready", rx_ready, 1);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_unmapped;
        wr(6'h23, 32'hFFFF);
        wr(6'h05, 32'hFFFF);
        wr(6'h3F, 32'hFFFF);
        rd_chk("R2 ctl4", 6'h23, 0);
        rd_chk("R2 hole 05", 6'h05, 0);
        rd_chk("R2 hole 3F", 6'h3F, 0);
        rd_chk("R2 binc", 6'h29, 0);
        rd_chk("R2 ctl1 untouched", 6'h20, 0);
        rd_chk("R2 ctl3 untouched", 6'h22, 32'h0700);
    endtask

    task automatic t_widths;
        wr(6'h22, 32'hDEAD5A5A); rd_chk("R3 ctl3", 6'h22, 32'h5A5A);
        wr(6'h24, 32'h12340F0F); rd_chk("R3 fifo", 6'h24, 32'h0F0F);
        wr(6'h2A, 32'hFFFF1357); rd_chk("R3 bmod", 6'h2A, 32'h1357);
        wr(6'h2C, 32'h0001ABCD); rd_chk("R3 msec", 6'h2C, 32'hABCD);
        wr(6'h29, 32'h00077777); rd_chk("R3 bcnt via binc", 6'h2B, 32'h7777);
        rd_chk("R3 binc reads zero", 6'h29, 0);
    endtask

    task automatic t_tx;
        wr(6'h10, 32'h55);
        chk("R8 disabled no strobe", tx_valid, 0);
        wr(6'h21, 32'h0005);
        wr(6'h10, 32'h1A5);
        chk("R8 strobe", tx_valid, 1);
        chk("R8 byte", tx_byte, 8'hA5);
        @(negedge clk); #1;
        chk("R8 single pulse", tx_valid, 0);
    endtask

    task automatic t_rx;
        rx_send(8'h3C, 0);
        chk("R5 rx_ready low", rx_ready, 0);
        rd_chk("R5 sts1 full", 6'h25, 32'h6240);
        rd_chk("R5 sts2 full", 6'h26, 32'h4029);
        rd_chk("R5 tst full", 6'h2D, 32'h0040);
        rx_send(8'h77, 0);
        rd_chk("R5/R7 first char kept", 6'h00, 32'h803C);
        rd_chk("R7 sts1 freed", 6'h25, 32'h6040);
        rd_chk("R7 sts2 freed", 6'h26, 32'h4028);
        rd_chk("R7 tst freed", 6'h2D, 32'h0060);
        rd_chk("R7 empty read", 6'h00, 32'h003C);
        chk("R7 rx_ready", rx_ready, 1);
    endtask

    task automatic t_break;
        rx_send(8'hFF, 1);
        rd_chk("R6 break sts1", 6'h25, 32'h6240);
        rd_chk("R6 break value", 6'h00, 32'h8800);
    endtask

    task automatic t_w1c;
        rx_send(8'h01, 0);
        wr(6'h25, 32'hFFFF);
        wr(6'h26, 32'hFFFF);
        rd_chk("R9 sts1 kept", 6'h25, 32'h6240);
        rd_chk("R9 sts2 kept", 6'h26, 32'h4029);
        rd_chk("R9 drain", 6'h00, 32'h8001);
    endtask

    task automatic t_irq;
        wr(6'h20, 32'h2000); chk("R10 trdy without empty-enable", irq, 0);
        wr(6'h20, 32'h2040); chk("R10 trdy with empty-enable", irq, 1);
        wr(6'h20, 32'h0200); chk("R10 rrdy enabled empty", irq, 0);
        rx_send(8'h42, 0);   chk("R10 rrdy raised", irq, 1);
        rd_chk("R10 drain", 6'h00, 32'h8042);
        chk("R10 rrdy dropped", irq, 0);
        wr(6'h20, 32'h0000);
    endtask

    task automatic t_srst;
        wr(6'h24, 32'h0011);
        wr(6'h2C, 32'h0022);
        wr(6'h20, 32'h0001);
        wr(6'h22, 32'h0001);
        wr(6'h29, 32'h0099);
        rx_send(8'h5E, 0);
        wr(6'h21, 32'h00F4);
        rd_chk("R4 ctl2 forced", 6'h21, 32'h00F5);
        rd_chk("R4 ctl1", 6'h20, 0);
        rd_chk("R4 ctl3", 6'h22, 32'h0700);
        rd_chk("R4 bcnt", 6'h2B, 32'h0004);
        rd_chk("R4 buffer emptied", 6'h00, 32'h4000);
        chk("R4 rx_ready", rx_ready, 1);
        rd_chk("R4 fifo kept", 6'h24, 32'h0011);
        rd_chk("R4 msec kept", 6'h2C, 32'h0022);
    endtask

    task automatic t_collide;
        rx_send(8'h11, 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h00;
        rx_valid = 1'b1; rx_byte = 8'h22;
        #1;
        chk("R7 collide read", rd_data, 32'h8011);
        chk("R5 collide held off", rx_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R5 collide freed", rx_ready, 1);
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
        chk("R5 collide taken", rx_ready, 0);
        rd_chk("R5 collide second char", 6'h00, 32'h8022);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_unmapped();
        t_widths();
        t_tx();
        t_rx();
        t_break();
        t_w1c();
        t_irq();
        t_srst();
        t_collide();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule